// File: doc/BRIEF.md
# Bus-Programmed Instruction Memory Loader

This block lets a host processor fill a small CPU's 256-byte instruction store over a Wishbone slave port. It also lets the host set a 32-bit clock-frequency word that a serial unit elsewhere on the chip uses. The slave decodes two word addresses inside its window.

A program write carries both fields in one 32-bit data word: the byte to store sits in the low byte, and the store location sits in the next byte up. The memory is never mapped linearly onto the bus. The second word address holds the frequency register, which can be written byte by byte and read back.

The CPU reads the store through a separate synchronous fetch port. It presents an address, and the byte appears one clock later.

Top module: `imem_loader`

## Requirements
- R1: Each clock cycle in which both `wbCyc` and `wbStb` are high is answered by `wbAck` high in the following cycle only. A cycle without that request is followed by `wbAck` low.
- R2: A write to `BASE_ADDR` (word offset 0x0) with `wbSel[0]` and `wbSel[1]` both set stores `wbDatW[7:0]` at memory location `wbDatW[15:8]`. The setting of `wbSel[3:2]` does not matter.
- R3: A write to `BASE_ADDR` with `wbSel[0]` or `wbSel[1]` clear changes no memory location.
- R4: A write to `BASE_ADDR+4` updates byte n of the frequency register from `wbDatW` byte n for each n with `wbSel[n]` set. `clkFreq` shows the new value from the cycle after the request.
- R5: A read of `BASE_ADDR+4` returns the frequency register on `wbDatR` during the acknowledge cycle. A read of `BASE_ADDR` returns zero.
- R6: A request to any other address is acknowledged. As a write it changes neither the memory nor the frequency register, and as a read it returns zero.
- R7: `fetchData` holds the memory byte at the `fetchAddr` value sampled at the previous clock edge. If a program write to the same location lands at that edge, the fetch returns the byte stored before the write.
- R8: While `rst` is high, every memory location is cleared and the frequency register is loaded with `FREQ_RST` (default 0). `wbAck`, `wbDatR` and `fetchData` are driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wbCyc | input | 1 | Bus cycle active |
| wbStb | input | 1 | Request strobe |
| wbWe | input | 1 | Write enable (1 = write) |
| wbAdr | input | 32 | Byte address |
| wbDatW | input | 32 | Write data |
| wbSel | input | 4 | Byte-lane enables |
| wbDatR | output | 32 | Read data, valid with `wbAck` |
| wbAck | output | 1 | Acknowledge, one cycle after the request |
| fetchAddr | input | ADDR_W | CPU fetch address |
| fetchData | output | 8 | CPU fetch byte, one cycle after the address |
| clkFreq | output | 32 | Stored clock-frequency word |

## Verification
Every result of this block is due exactly one clock after its cause:
- `wbAck` and `wbDatR` follow the request edge.
- `clkFreq` follows the write edge.
- `fetchData` follows the edge at which `fetchAddr` was sampled.

The bench drives inputs at the falling edge and holds a request for exactly one rising edge. It samples the matching output at the next falling edge, half a cycle after the edge that produces it. For the collision case it samples on two successive falling edges, which show the old byte and then the new one.

// File: rtl/imem_loader_pkg.sv
package imem_loader_pkg;
  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic             progWe;
    logic [LANES-1:0] freqWe;
    logic             rdFreq;
  } strobe_t;
endpackage

// File: rtl/imem_loader_ctrl.sv
module imem_loader_ctrl
  import imem_loader_pkg::*;
#(
  parameter logic [BUS_W-1:0] BASE_ADDR = 32'h3000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wbCyc,
  input  logic             wbStb,
  input  logic             wbWe,
  input  logic [BUS_W-1:0] wbAdr,
  input  logic [LANES-1:0] wbSel,
  output strobe_t          strb,
  output logic             wbAck
);
  localparam logic [BUS_W-3:0] PROG_WORD = BASE_ADDR[BUS_W-1:2];
  localparam logic [BUS_W-3:0] FREQ_WORD = PROG_WORD + 1'b1;

  logic reqValid;
  logic hitProg;
  logic hitFreq;

  assign reqValid = wbCyc & wbStb;
  assign hitProg  = (wbAdr[BUS_W-1:2] == PROG_WORD);
  assign hitFreq  = (wbAdr[BUS_W-1:2] == FREQ_WORD);

  always_comb begin
    strb.progWe = reqValid & wbWe & hitProg & wbSel[0] & wbSel[1];
    strb.freqWe = {LANES{reqValid & wbWe & hitFreq}} & wbSel;
    strb.rdFreq = reqValid & ~wbWe & hitFreq;
  end

  always_ff @(posedge clk) begin
    if (rst) wbAck <= 1'b0;
    else     wbAck <= reqValid;
  end

  // R1
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb) |=> wbAck);

  // R1
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !(wbCyc && wbStb) |=> !wbAck);
endmodule

// File: rtl/imem_loader_dp.sv
module imem_loader_dp
  import imem_loader_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [BUS_W-1:0] FREQ_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [BUS_W-1:0]  wbDatW,
  output logic [BUS_W-1:0]  wbDatR,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [BYTE_W-1:0] fetchData,
  output logic [BUS_W-1:0]  clkFreq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] progAdr;
  logic [BYTE_W-1:0] progByte;
  logic [BUS_W-1:0]  freqReg;

  assign progByte = wbDatW[BYTE_W-1:0];
  assign progAdr  = wbDatW[BYTE_W +: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.progWe) begin
      mem[progAdr] <= progByte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fetchData <= '0;
    else     fetchData <= mem[fetchAddr];
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst)                 freqReg[g*8 +: 8] <= FREQ_RST[g*8 +: 8];
      else if (strb.freqWe[g]) freqReg[g*8 +: 8] <= wbDatW[g*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              wbDatR <= '0;
    else if (strb.rdFreq) wbDatR <= freqReg;
    else                  wbDatR <= '0;
  end

  assign clkFreq = freqReg;

  // R4
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.freqWe == '0) |=> $stable(freqReg));
endmodule

// File: rtl/imem_loader.sv
module imem_loader
  import imem_loader_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter logic [31:0]      BASE_ADDR = 32'h3000_0000,
  parameter logic [31:0]      FREQ_RST  = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [31:0]       wbAdr,
  input  logic [31:0]       wbDatW,
  input  logic [3:0]        wbSel,
  output logic [31:0]       wbDatR,
  output logic              wbAck,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [7:0]        fetchData,
  output logic [31:0]       clkFreq
);
  strobe_t strb;

  imem_loader_ctrl #(.BASE_ADDR(BASE_ADDR)) ctrl_i (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbSel(wbSel), .strb(strb), .wbAck(wbAck)
  );

  imem_loader_dp #(.ADDR_W(ADDR_W), .FREQ_RST(FREQ_RST)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .wbDatW(wbDatW), .wbDatR(wbDatR),
    .fetchAddr(fetchAddr), .fetchData(fetchData), .clkFreq(clkFreq)
  );

  logic isProgAdr;
  logic isMapped;
  assign isProgAdr = (wbAdr[31:2] == BASE_ADDR[31:2]);
  assign isMapped  = isProgAdr || (wbAdr[31:2] == (BASE_ADDR[31:2] + 30'd1));

  // R5
  prog_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbWe && isProgAdr) |=> (wbDatR == 32'h0));

  // R6
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && wbWe && !isMapped) |=> $stable(clkFreq));

  // R6
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbWe && !isMapped) |=> (wbDatR == 32'h0));

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wbAck && wbDatR == 32'h0 && fetchData == 8'h0 && clkFreq == FREQ_RST));
endmodule

// File: tb/imem_loader_tb.sv
module imem_loader_tb_top;
  localparam logic [31:0] BASE = 32'h3000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        wbCyc, wbStb, wbWe;
  logic [31:0] wbAdr, wbDatW, wbDatR, clkFreq;
  logic [3:0]  wbSel;
  logic        wbAck;
  logic [7:0]  fetchAddr, fetchData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] freqModel;

  always #5 clk = ~clk;

  imem_loader dut_i (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatW(wbDatW), .wbSel(wbSel), .wbDatR(wbDatR),
    .wbAck(wbAck), .fetchAddr(fetchAddr), .fetchData(fetchData),
    .clkFreq(clkFreq)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request held for exactly one rising edge; ack and data sampled at the next falling edge.
  task automatic xfer(input logic we, input logic [31:0] adr, input logic [31:0] dat,
                      input logic [3:0] sel, output logic [31:0] rd);
    @(negedge clk);
    check("R1 idle before request", {31'b0, wbAck}, 32'd0);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = we; wbAdr = adr; wbDatW = dat; wbSel = sel;
    @(negedge clk);
    check("R1 ack after request", {31'b0, wbAck}, 32'd1);
    rd = wbDatR;
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
  endtask

  task automatic fetch(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    fetchAddr = a;
    @(negedge clk);
    d = fetchData;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  d;
    rst = 1'b1; wbCyc = 0; wbStb = 0; wbWe = 0; wbAdr = 0; wbDatW = 0; wbSel = 0;
    fetchAddr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state at the ports
    check("R8 ack", {31'b0, wbAck}, 32'd0);
    check("R8 rdata", wbDatR, 32'd0);
    check("R8 freq", clkFreq, 32'd0);
    check("R8 fetch", {24'b0, fetchData}, 32'd0);
    for (int a = 0; a < 256; a++) begin
      fetch(8'(a), d);
      check("R8 cleared memory", {24'b0, d}, 32'd0);
    end

    // R2 fill every location, then R7 read all back
    for (int a = 0; a < 256; a++)
      xfer(1'b1, BASE, {16'h0, 8'(a), pat(a)}, 4'b0011, rd);
    for (int a = 0; a < 256; a++) begin
      fetch(8'(a), d);
      check("R2/R7 stored byte", {24'b0, d}, {24'b0, pat(a)});
    end

    // R2 / R3 every lane pattern
    for (int s = 0; s < 16; s++) begin
      xfer(1'b1, BASE, {16'hBEEF, 8'(8'h40 + s), 8'(8'hA0 + s)}, 4'(s), rd);
      fetch(8'(8'h40 + s), d);
      if (s[1:0] == 2'b11) check("R2 lanes enabled", {24'b0, d}, {24'b0, 8'(8'hA0 + s)});
      else                 check("R3 lanes missing", {24'b0, d}, {24'b0, pat(8'h40 + s)});
    end

    // R4 / R5 frequency register with every lane pattern
    freqModel = 32'h0;
    for (int s = 0; s < 16; s++) begin
      logic [31:0] v;
      v = 32'h1357_9BDF ^ (32'(s) * 32'h0101_0101);
      xfer(1'b1, BASE + 4, v, 4'(s), rd);
      for (int l = 0; l < 4; l++) if (s[l]) freqModel[l*8 +: 8] = v[l*8 +: 8];
      check("R4 clkFreq lanes", clkFreq, freqModel);
      xfer(1'b0, BASE + 4, 32'h0, 4'hF, rd);
      check("R5 read freq", rd, freqModel);
    end
    xfer(1'b0, BASE, 32'h0, 4'hF, rd);
    check("R5 read prog offset zero", rd, 32'h0);

    // R6 unmapped addresses
    begin
      logic [31:0] adrs [5];
      adrs[0] = BASE + 8; adrs[1] = BASE + 12; adrs[2] = BASE + 16;
      adrs[3] = 32'h0;    adrs[4] = BASE - 4;
      for (int k = 0; k < 5; k++) begin
        xfer(1'b1, adrs[k], {16'h0, 8'h20, 8'hFF}, 4'hF, rd);
        check("R6 freq unchanged", clkFreq, freqModel);
        fetch(8'h20, d);
        check("R6 memory unchanged", {24'b0, d}, {24'b0, pat(8'h20)});
        xfer(1'b0, adrs[k], 32'h0, 4'hF, rd);
        check("R6 read zero", rd, 32'h0);
      end
    end

    // R7 fetch and write to the same location at one edge
    @(negedge clk);
    fetchAddr = 8'h30;
    wbCyc = 1; wbStb = 1; wbWe = 1; wbAdr = BASE; wbDatW = {16'h0, 8'h30, 8'h5A}; wbSel = 4'b0011;
    @(negedge clk);
    wbCyc = 0; wbStb = 0; wbWe = 0;
    check("R7 collision old byte", {24'b0, fetchData}, {24'b0, pat(8'h30)});
    @(negedge clk);
    check("R7 new byte next cycle", {24'b0, fetchData}, 32'h5A);
    check("R1 ack drops", {31'b0, wbAck}, 32'd0);

    // R1 back-to-back requests each get an ack
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = 0; wbAdr = BASE + 4; wbSel = 4'hF;
    @(negedge clk);
    check("R1 first ack", {31'b0, wbAck}, 32'd1);
    @(negedge clk);
    check("R1 second ack", {31'b0, wbAck}, 32'd1);
    check("R5 streaming read", wbDatR, freqModel);
    wbCyc = 0; wbStb = 0;
    @(negedge clk);
    check("R1 no ack after stop", {31'b0, wbAck}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule